// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Error Flags

This block turns an asynchronous serial line into characters. A free-running strobe at sixteen times the bit rate drives the timing. A falling line level in idle starts a frame. Half a bit later the start bit is sampled again to confirm it. Every later bit is sampled at its centre and shifted in, least significant bit first. When the last stop bit has been sampled, the character moves into a single-entry holding buffer. A one-cycle interrupt pulse marks that move.

The character can be 7, 8 or 9 bits long. An optional parity bit can be checked against odd or even parity, and one or two stop bits can be selected. The buffer keeps three error flags: overrun, framing and parity. A fourth output is the OR of all three.

A request-to-send output can tell the far end when the receiver is ready to take a character. The divider that makes the sampling strobe and any host bus logic sit outside this block. The line input is taken as already synchronous to the clock.

Top module: `uart_rx_flags`

## Requirements
- R1: A frame begins only while `rx_en_i` is 1 and a low line is seen on a strobe in idle. The line is re-sampled on the eighth strobe after that. If it is high again, the receiver returns to idle and no character is produced.
- R2: `char_len_i` selects the character length: 0 gives 7 bits, 2 gives 9 bits, and 1 or 3 gives 8 bits. Bits arrive least significant first. `data_o` holds the character right-aligned, with the unused upper bits at 0.
- R3: When a character completes and the buffer is empty, or is read in that same cycle, `full_o` rises and `rx_irq_o` is high for exactly one cycle, in the same cycle.
- R4: When a character completes while `full_o` is 1 and `rd_i` is 0, the new character replaces the buffer contents and `ovr_err_o` is set. `rx_irq_o` stays low for that character.
- R5: `frm_err_o` is set with the character when any configured stop bit is sampled low. `two_stop_i` = 1 selects two stop bits and 0 selects one.
- R6: With `par_en_i` = 1, a parity bit follows the data bits. `par_err_o` is set when the count of ones in data plus parity is odd while `par_odd_i` = 0, or even while `par_odd_i` = 1.
- R7: `err_sum_o` is 1 exactly when at least one of overrun, framing and parity error is set.
- R8: A one-cycle `rd_i` clears `full_o` and all error flags. If it falls in the cycle a character completes, the new character is loaded with its own flags and no overrun is recorded.
- R9: While `rx_en_i` is 0, a frame in progress is abandoned and the error flags are cleared. `full_o` and `data_o` are kept until read.
- R10: With `rts_en_i` = 1, `rts_o` is 0 while the receiver is enabled and the buffer is empty, and 1 otherwise. With `rts_en_i` = 0, `rts_o` is 0.
- R11: After reset, `full_o`, all error flags, `rx_irq_o` and `data_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line, idle high |
| tick_i | input | 1 | Sampling strobe at 16x the bit rate |
| rx_en_i | input | 1 | Receiver enable |
| rd_i | input | 1 | Buffer read strobe |
| char_len_i | input | 2 | Character length code |
| par_en_i | input | 1 | Parity bit present |
| par_odd_i | input | 1 | 1 for odd parity, 0 for even |
| two_stop_i | input | 1 | 1 for two stop bits |
| rts_en_i | input | 1 | Request-to-send output enable |
| data_o | output | 9 | Received character, right-aligned |
| full_o | output | 1 | Buffer holds an unread character |
| ovr_err_o | output | 1 | Overrun error |
| frm_err_o | output | 1 | Framing error |
| par_err_o | output | 1 | Parity error |
| err_sum_o | output | 1 | OR of the three error flags |
| rts_o | output | 1 | Request-to-send, low when ready |
| rx_irq_o | output | 1 | Receive interrupt pulse |

## Verification
A buffer read and a character load can fall in the same cycle. In that cycle the read must not cancel the load, and the full buffer must not count as an overrun.

The bench first fills the buffer with one character. It then sends a second frame and raises the read strobe for one cycle, exactly on the edge that loads it. That edge is counted from the start bit: 153 clocks for an 8-bit frame with one stop bit. The bench expects the second character in the buffer, the buffer still full, no overrun flag, and one more interrupt pulse.

A design that lets the read win would show an empty buffer. One that ignores the read would show an overrun.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  localparam int unsigned MAX_BITS  = 9;
  localparam int unsigned BIT_IDX_W = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP1, ST_STOP2
  } rx_state_e;

  typedef struct packed {
    logic [MAX_BITS-1:0] data;
    logic                frm_err;
    logic                par_err;
  } rx_char_t;

  function automatic logic [BIT_IDX_W-1:0] char_bits(input logic [1:0] code);
    case (code)
      2'd0:    return BIT_IDX_W'(7);
      2'd2:    return BIT_IDX_W'(9);
      default: return BIT_IDX_W'(8);
    endcase
  endfunction
endpackage

// File: rtl/uart_rx_frame.sv
module uart_rx_frame
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rxd_i,
  input  logic       tick_i,
  input  logic       en_i,
  input  logic [1:0] len_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       two_stop_i,
  output logic       done_o,
  output rx_char_t   char_o
);
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] CNT_HALF = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(OVS - 1);

  rx_state_e             state_q;
  logic [CNT_W-1:0]      cnt_q;
  logic [BIT_IDX_W-1:0]  idx_q;
  logic [BIT_IDX_W-1:0]  nbits;
  logic [MAX_BITS-1:0]   shreg_q;
  logic                  par_acc_q, frm_acc_q;
  logic                  done_q, frm_q, par_q;

  assign nbits = char_bits(len_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      idx_q     <= '0;
      shreg_q   <= '0;
      par_acc_q <= 1'b0;
      frm_acc_q <= 1'b0;
      done_q    <= 1'b0;
      frm_q     <= 1'b0;
      par_q     <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!en_i) begin
        state_q <= ST_IDLE;
      end else if (tick_i) begin
        case (state_q)
          ST_IDLE: begin
            if (!rxd_i) begin
              state_q <= ST_START;
              cnt_q   <= '0;
            end
          end
          ST_START: begin
            if (cnt_q == CNT_HALF) begin
              cnt_q     <= '0;
              idx_q     <= '0;
              par_acc_q <= 1'b0;
              state_q   <= rxd_i ? ST_IDLE : ST_DATA;  // false start
            end else begin
              cnt_q <= cnt_q + 1'b1;
            end
          end
          default: begin
            if (cnt_q != CNT_LAST) begin
              cnt_q <= cnt_q + 1'b1;
            end else begin
              cnt_q <= '0;
              case (state_q)
                ST_DATA: begin
                  shreg_q   <= {rxd_i, shreg_q[MAX_BITS-1:1]};
                  par_acc_q <= par_acc_q ^ rxd_i;
                  if (idx_q == nbits - 1'b1) state_q <= par_en_i ? ST_PAR : ST_STOP1;
                  else                       idx_q   <= idx_q + 1'b1;
                end
                ST_PAR: begin
                  par_acc_q <= par_acc_q ^ rxd_i;
                  state_q   <= ST_STOP1;
                end
                ST_STOP1: begin
                  frm_acc_q <= !rxd_i;
                  if (two_stop_i) begin
                    state_q <= ST_STOP2;
                  end else begin
                    state_q <= ST_IDLE;
                    done_q  <= 1'b1;
                    frm_q   <= !rxd_i;
                    par_q   <= par_en_i && (par_acc_q != par_odd_i);
                  end
                end
                default: begin
                  state_q <= ST_IDLE;
                  done_q  <= 1'b1;
                  frm_q   <= frm_acc_q | !rxd_i;
                  par_q   <= par_en_i && (par_acc_q != par_odd_i);
                end
              endcase
            end
          end
        endcase
      end
    end
  end

  assign done_o         = done_q;
  assign char_o.data    = shreg_q >> (BIT_IDX_W'(MAX_BITS) - nbits);
  assign char_o.frm_err = frm_q;
  assign char_o.par_err = par_q;
endmodule

// File: rtl/uart_rx_buffer.sv
module uart_rx_buffer
  import uart_rx_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                rd_i,
  input  logic                load_i,
  input  rx_char_t            char_i,
  output logic [MAX_BITS-1:0] data_o,
  output logic                full_o,
  output logic                ovr_o,
  output logic                frm_o,
  output logic                par_o,
  output logic                irq_o
);
  logic [MAX_BITS-1:0] data_q;
  logic full_q, ovr_q, frm_q, par_q, irq_q;
  logic overrun;

  assign overrun = full_q & ~rd_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      full_q <= 1'b0;
      ovr_q  <= 1'b0;
      frm_q  <= 1'b0;
      par_q  <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (!en_i) begin
        ovr_q <= 1'b0;
        frm_q <= 1'b0;
        par_q <= 1'b0;
        if (rd_i) full_q <= 1'b0;
      end else if (load_i) begin
        data_q <= char_i.data;
        full_q <= 1'b1;
        ovr_q  <= overrun | (ovr_q & ~rd_i);
        frm_q  <= char_i.frm_err | (frm_q & ~rd_i);
        par_q  <= char_i.par_err | (par_q & ~rd_i);
        irq_q  <= ~overrun;
      end else if (rd_i) begin
        full_q <= 1'b0;
        ovr_q  <= 1'b0;
        frm_q  <= 1'b0;
        par_q  <= 1'b0;
      end
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign ovr_o  = ovr_q;
  assign frm_o  = frm_q;
  assign par_o  = par_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/uart_rx_flags.sv
module uart_rx_flags
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                rxd_i,
  input  logic                tick_i,
  input  logic                rx_en_i,
  input  logic                rd_i,
  input  logic [1:0]          char_len_i,
  input  logic                par_en_i,
  input  logic                par_odd_i,
  input  logic                two_stop_i,
  input  logic                rts_en_i,
  output logic [MAX_BITS-1:0] data_o,
  output logic                full_o,
  output logic                ovr_err_o,
  output logic                frm_err_o,
  output logic                par_err_o,
  output logic                err_sum_o,
  output logic                rts_o,
  output logic                rx_irq_o
);
  logic     frame_done;
  rx_char_t frame_char;

  uart_rx_frame #(.OVS(OVS)) u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rxd_i      (rxd_i),
    .tick_i     (tick_i),
    .en_i       (rx_en_i),
    .len_i      (char_len_i),
    .par_en_i   (par_en_i),
    .par_odd_i  (par_odd_i),
    .two_stop_i (two_stop_i),
    .done_o     (frame_done),
    .char_o     (frame_char)
  );

  uart_rx_buffer u_buf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rx_en_i),
    .rd_i   (rd_i),
    .load_i (frame_done),
    .char_i (frame_char),
    .data_o (data_o),
    .full_o (full_o),
    .ovr_o  (ovr_err_o),
    .frm_o  (frm_err_o),
    .par_o  (par_err_o),
    .irq_o  (rx_irq_o)
  );

  assign err_sum_o = ovr_err_o | frm_err_o | par_err_o;
  assign rts_o     = rts_en_i & ~(rx_en_i & ~full_o);
endmodule

// File: rtl/uart_rx_flags_chk.sv
module uart_rx_flags_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic rx_en_i,
  input logic rd_i,
  input logic frame_done,
  input logic full_o,
  input logic ovr_err_o,
  input logic err_sum_o,
  input logic rx_irq_o
);
  assert_irq_single_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |=> !rx_irq_o);

  assert_irq_with_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_irq_o |-> (full_o && !ovr_err_o));

  assert_load_sets_full_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_done && rx_en_i) |=> full_o);

  assert_ovr_no_irq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_err_o) |-> ($past(full_o) && !rx_irq_o));

  assert_flags_need_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_sum_o |-> full_o);

  assert_read_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !frame_done) |=> (!full_o && !err_sum_o));

  assert_disable_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !err_sum_o);
endmodule

bind uart_rx_flags uart_rx_flags_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rx_en_i    (rx_en_i),
  .rd_i       (rd_i),
  .frame_done (frame_done),
  .full_o     (full_o),
  .ovr_err_o  (ovr_err_o),
  .err_sum_o  (err_sum_o),
  .rx_irq_o   (rx_irq_o)
);

// File: tb/uart_rx_flags_tb.sv
module uart_rx_flags_tb;
  localparam int CLK_PERIOD = 10;
  localparam int OVS        = 16;
  localparam int NVEC       = 11;

  logic       clk_i = 1'b0;
  logic       rst_ni, rxd_i, tick_i, rx_en_i, rd_i;
  logic [1:0] char_len_i;
  logic       par_en_i, par_odd_i, two_stop_i, rts_en_i;
  logic [8:0] data_o;
  logic       full_o, ovr_err_o, frm_err_o, par_err_o, err_sum_o, rts_o, rx_irq_o;

  typedef struct packed {
    logic [1:0] len;
    logic       pen;
    logic       podd;
    logic       two;
    logic [8:0] data;
    logic       flip;
    logic       bad1;
    logic       bad2;
    logic       exp_par;
    logic       exp_frm;
  } vec_t;

  localparam vec_t VECS [NVEC] = '{
    '{2'd1, 1'b0, 1'b0, 1'b0, 9'h0A5, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'd0, 1'b0, 1'b0, 1'b0, 9'h05A, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'd2, 1'b0, 1'b0, 1'b0, 9'h1C3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'd1, 1'b1, 1'b0, 1'b0, 9'h037, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'd1, 1'b1, 1'b1, 1'b0, 9'h037, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'd1, 1'b1, 1'b0, 1'b0, 9'h0C8, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{2'd0, 1'b1, 1'b1, 1'b0, 9'h019, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
    '{2'd1, 1'b0, 1'b0, 1'b0, 9'h081, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1},
    '{2'd1, 1'b0, 1'b0, 1'b1, 9'h07E, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1},
    '{2'd2, 1'b1, 1'b1, 1'b1, 9'h155, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{2'd3, 1'b1, 1'b0, 1'b0, 9'h0F0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1}
  };

  int checks   = 0;
  int fails    = 0;
  int irq_cnt  = 0;
  int base;

  uart_rx_flags #(.OVS(OVS)) u_dut (
    .clk_i, .rst_ni, .rxd_i, .tick_i, .rx_en_i, .rd_i, .char_len_i,
    .par_en_i, .par_odd_i, .two_stop_i, .rts_en_i, .data_o, .full_o,
    .ovr_err_o, .frm_err_o, .par_err_o, .err_sum_o, .rts_o, .rx_irq_o
  );

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  always @(posedge clk_i) if (rx_irq_o) irq_cnt <= irq_cnt + 1;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send(input vec_t v, input int rd_at);
    int n, nb;
    logic [13:0] fr;
    logic ones;
    n  = (v.len == 2'd0) ? 7 : ((v.len == 2'd2) ? 9 : 8);
    fr = '1;
    ones = 1'b0;
    fr[0] = 1'b0;
    nb = 1;
    for (int i = 0; i < n; i++) begin
      fr[nb] = v.data[i];
      ones   = ones ^ v.data[i];
      nb++;
    end
    if (v.pen) begin
      fr[nb] = ones ^ v.podd ^ v.flip;
      nb++;
    end
    fr[nb] = ~v.bad1;
    nb++;
    if (v.two) begin
      fr[nb] = ~v.bad2;
      nb++;
    end
    char_len_i = v.len;
    par_en_i   = v.pen;
    par_odd_i  = v.podd;
    two_stop_i = v.two;
    for (int c = 0; c < nb * OVS + 2 * OVS; c++) begin
      @(negedge clk_i);
      rxd_i = (c / OVS < nb) ? fr[c / OVS] : 1'b1;
      rd_i  = (c == rd_at);
    end
    @(negedge clk_i);
    rd_i = 1'b0;
  endtask

  task automatic read_buf();
    @(negedge clk_i);
    rd_i = 1'b1;
    @(negedge clk_i);
    rd_i = 1'b0;
    @(negedge clk_i);
  endtask

  function automatic vec_t plain(input logic [8:0] d);
    return '{2'd1, 1'b0, 1'b0, 1'b0, d, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0};
  endfunction

  initial begin
    repeat (100000) @(posedge clk_i);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; rxd_i = 1'b1; tick_i = 1'b1; rx_en_i = 1'b1; rd_i = 1'b0;
    char_len_i = 2'd1; par_en_i = 1'b0; par_odd_i = 1'b0; two_stop_i = 1'b0;
    rts_en_i = 1'b1;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    check("R11 full", 32'(full_o), 32'd0);
    check("R11 data", 32'(data_o), 32'd0);
    check("R11 flags", 32'({ovr_err_o, frm_err_o, par_err_o, err_sum_o}), 32'd0);
    check("R11 irq", 32'(irq_cnt), 32'd0);
    check("R10 rts ready", 32'(rts_o), 32'd0);

    for (int k = 0; k < NVEC; k++) begin
      base = irq_cnt;
      send(VECS[k], -1);
      check("R2 data", 32'(data_o), 32'(VECS[k].data));
      check("R6 parity", 32'(par_err_o), 32'(VECS[k].exp_par));
      check("R5 framing", 32'(frm_err_o), 32'(VECS[k].exp_frm));
      check("R7 sum", 32'(err_sum_o), 32'(VECS[k].exp_par | VECS[k].exp_frm));
      check("R3 full", 32'(full_o), 32'd1);
      check("R3 irq", 32'(irq_cnt), 32'(base + 1));
      read_buf();
      check("R8 read clears", 32'({full_o, err_sum_o}), 32'd0);
    end

    // R1: disabled receiver ignores a frame
    rx_en_i = 1'b0;
    base = irq_cnt;
    send(plain(9'h03C), -1);
    check("R1 disabled full", 32'(full_o), 32'd0);
    check("R1 disabled irq", 32'(irq_cnt), 32'(base));
    check("R10 rts disabled rx", 32'(rts_o), 32'd1);
    rx_en_i = 1'b1;
    @(negedge clk_i);

    // R1: false start glitch
    rxd_i = 1'b0;
    repeat (5) @(negedge clk_i);
    rxd_i = 1'b1;
    repeat (40) @(negedge clk_i);
    check("R1 false start full", 32'(full_o), 32'd0);
    check("R1 false start irq", 32'(irq_cnt), 32'(base));
    send(plain(9'h096), -1);
    check("R1 after glitch data", 32'(data_o), 32'h096);
    read_buf();

    // R4: overrun
    base = irq_cnt;
    send(plain(9'h011), -1);
    send(plain(9'h022), -1);
    check("R4 data overwritten", 32'(data_o), 32'h022);
    check("R4 overrun flag", 32'(ovr_err_o), 32'd1);
    check("R7 sum on overrun", 32'(err_sum_o), 32'd1);
    check("R4 irq suppressed", 32'(irq_cnt), 32'(base + 1));
    check("R10 rts full", 32'(rts_o), 32'd1);
    read_buf();
    check("R8 overrun cleared", 32'({full_o, ovr_err_o}), 32'd0);
    check("R10 rts empty", 32'(rts_o), 32'd0);

    // R8: read coincides with load (edge 153 for 8N1)
    base = irq_cnt;
    send(plain(9'h033), -1);
    send(plain(9'h044), 153);
    check("R8 collision data", 32'(data_o), 32'h044);
    check("R8 collision full", 32'(full_o), 32'd1);
    check("R8 collision no overrun", 32'(ovr_err_o), 32'd0);
    check("R8 collision irq", 32'(irq_cnt), 32'(base + 2));
    read_buf();

    // R9: disabling clears flags, keeps character
    send(VECS[5], -1);
    check("R9 parity before", 32'(par_err_o), 32'd1);
    @(negedge clk_i);
    rx_en_i = 1'b0;
    repeat (2) @(negedge clk_i);
    check("R9 flags cleared", 32'({par_err_o, err_sum_o}), 32'd0);
    check("R9 full kept", 32'(full_o), 32'd1);
    check("R9 data kept", 32'(data_o), 32'h0C8);
    rts_en_i = 1'b0;
    @(negedge clk_i);
    check("R10 rts off", 32'(rts_o), 32'd0);
    rts_en_i = 1'b1;
    rx_en_i = 1'b1;
    read_buf();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule